// File: doc/BRIEF.md
# Scan Test Application Sequencer

This block runs a full-scan test on a circuit whose flip-flops are stitched into one serial chain. Each test vector arrives on a ready/valid port. It carries the primary-input bits, the present-state bits to load into the chain, and the expected primary-output and next-state bits. The sequencer shifts the present state into the chain and holds the primary inputs. It then switches the chain to its functional path for a single capture clock. The captured state comes out on scan-out during the clocks that load the following vector.

The chain advances only on cycles where the sequencer raises the chain clock enable. When no vector is waiting, the enable stays low and nothing in the chain moves. After the last capture, one unload pass shifts out the final response. Mismatches set a sticky flag and are counted once per failing vector. A one-cycle completion pulse marks the point where the number of enabled clocks equals the closed-form total.

Top module: `scanseq_top`

## Requirements
- R1: After reset, `scan_ce` and `done` are low, `vec_ready` is high, `fail_flag` is low and `fail_count` is zero.
- R2: While waiting for a vector with none offered, `scan_ce` stays low and `vec_ready` stays high, so the chain does not advance.
- R3: Each vector is loaded by exactly NUM_SFF cycles with `scan_ce`=1 and `scan_mode`=1. `scan_in` carries present-state bit NUM_SFF-1 first and bit 0 last. The chain shifts toward `scan_out`, which shows its last stage.
- R4: Exactly one capture cycle (`scan_ce`=1, `scan_mode`=0) follows each load. `core_pi` equals the vector's primary-input bits throughout the load and the capture.
- R5: A vector is taken on a clock edge where `vec_valid` and `vec_ready` are both high. `vec_ready` is high in the waiting state and in the capture cycle of every vector but the last. It is low during shifting, so back-to-back vectors leave no idle cycle.
- R6: `core_po` is compared with the expected primary outputs in the capture cycle. The following shift phase compares each `scan_out` bit with the expected next-state bit of the same index, highest index first.
- R7: After the final capture, NUM_SFF unload cycles with `scan_mode`=1 shift out and compare the last response. No further vector is accepted after that.
- R8: `fail_count` rises by one for each vector whose primary-output or next-state comparison shows any mismatch. The update happens at the end of the shift phase that checks that vector's next state.
- R9: `fail_flag` is set by the first mismatch and stays high until reset.
- R10: Over a whole run, the number of cycles with `scan_ce`=1 is (VEC_COUNT+1)·NUM_SFF+VEC_COUNT. `done` is a one-cycle pulse in the cycle after the last unload edge. From then on `scan_ce` remains low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_valid | input | 1 | A test vector is offered |
| vec_ready | output | 1 | Sequencer accepts a vector this cycle |
| vec_pi | input | NUM_PI | Primary-input bits of the vector |
| vec_ps | input | NUM_SFF | Present-state bits to load into the chain |
| vec_exp_po | input | NUM_PO | Expected primary outputs at capture |
| vec_exp_ns | input | NUM_SFF | Expected captured next state |
| scan_ce | output | 1 | Chain clock enable |
| scan_mode | output | 1 | 1 = shift path, 0 = functional capture |
| scan_in | output | 1 | Serial bit into the chain |
| core_pi | output | NUM_PI | Primary inputs applied to the circuit |
| scan_out | input | 1 | Serial bit from the chain's last stage |
| core_po | input | NUM_PO | Primary outputs of the circuit |
| fail_flag | output | 1 | Sticky mismatch indicator |
| fail_count | output | $clog2(VEC_COUNT+1) | Number of failing vectors |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with NUM_PI=3, NUM_PO=2, NUM_SFF=5 and VEC_COUNT=5. The expected enabled-clock total is therefore 35, and a whole run, including a stall and back-to-back acceptance, stays within a few dozen cycles. With a chain this short, every shift index is exercised on every vector, including bit 0, which is both the last bit loaded and the last bit compared. Injected wrong expectations hit the capture check, a mid-chain next-state bit and the final unload bit, so each path into the failure count is reached.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;

    typedef enum logic [2:0] {
        ST_WAIT   = 3'd0,
        ST_SHIFT  = 3'd1,
        ST_CAPT   = 3'd2,
        ST_UNLOAD = 3'd3,
        ST_HALT   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/scanseq_ctrl.sv
module scanseq_ctrl
    import scanseq_pkg::*;
#(
    parameter int NUM_PI    = 4,
    parameter int NUM_PO    = 3,
    parameter int NUM_SFF   = 8,
    parameter int VEC_COUNT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vec_valid_i,
    output logic               vec_ready_o,
    input  logic [NUM_PI-1:0]  vec_pi_i,
    input  logic [NUM_SFF-1:0] vec_ps_i,
    input  logic [NUM_PO-1:0]  vec_exp_po_i,
    input  logic [NUM_SFF-1:0] vec_exp_ns_i,
    output logic               chain_ce_o,
    output logic               chain_shift_o,
    output logic               chain_si_o,
    output logic [NUM_PI-1:0]  chain_pi_o,
    output logic [NUM_PO-1:0]  exp_po_o,
    output logic               exp_bit_o,
    output logic               cap_o,
    output logic               cmp_o,
    output logic               last_o,
    output logic               halt_o
);

    localparam int IW = (NUM_SFF > 1) ? $clog2(NUM_SFF) : 1;
    localparam int VW = $clog2(VEC_COUNT + 1);
    localparam logic [IW-1:0] TOP_IDX  = IW'(NUM_SFF - 1);
    localparam logic [VW-1:0] LAST_VEC = VW'(VEC_COUNT - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [IW-1:0]      idx;
        logic [VW-1:0]      nvec;
        logic [NUM_PI-1:0]  pi;
        logic [NUM_SFF-1:0] ps;
        logic [NUM_PO-1:0]  epo;
        logic [NUM_SFF-1:0] ens;
        logic [NUM_SFF-1:0] rns;
        logic               live;
    } ctrl_t;

    ctrl_t q, d;
    logic  ready, take;

    always_comb begin
        d     = q;
        ready = (q.st == ST_WAIT) || ((q.st == ST_CAPT) && (q.nvec != LAST_VEC));
        take  = vec_valid_i && ready;
        case (q.st)
            ST_WAIT: begin
                if (take) begin
                    d.st  = ST_SHIFT;
                    d.idx = TOP_IDX;
                    d.pi  = vec_pi_i;
                    d.ps  = vec_ps_i;
                    d.epo = vec_exp_po_i;
                    d.ens = vec_exp_ns_i;
                end
            end
            ST_SHIFT: begin
                if (q.idx == '0) d.st = ST_CAPT;
                else             d.idx = q.idx - 1'b1;
            end
            ST_CAPT: begin
                d.rns  = q.ens;
                d.live = 1'b1;
                d.nvec = q.nvec + 1'b1;
                if (q.nvec == LAST_VEC) begin
                    d.st  = ST_UNLOAD;
                    d.idx = TOP_IDX;
                end else if (take) begin
                    d.st  = ST_SHIFT;
                    d.idx = TOP_IDX;
                    d.pi  = vec_pi_i;
                    d.ps  = vec_ps_i;
                    d.epo = vec_exp_po_i;
                    d.ens = vec_exp_ns_i;
                end else begin
                    d.st = ST_WAIT;
                end
            end
            ST_UNLOAD: begin
                if (q.idx == '0) begin
                    d.st   = ST_HALT;
                    d.live = 1'b0;
                end else begin
                    d.idx = q.idx - 1'b1;
                end
            end
            default: d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_WAIT, default: '0};
        end else begin
            q <= d;
        end
    end

    assign vec_ready_o   = ready;
    assign chain_ce_o    = (q.st == ST_SHIFT) || (q.st == ST_CAPT) || (q.st == ST_UNLOAD);
    assign chain_shift_o = (q.st == ST_SHIFT) || (q.st == ST_UNLOAD);
    assign chain_si_o    = (q.st == ST_SHIFT) ? q.ps[q.idx] : 1'b0;
    assign chain_pi_o    = q.pi;
    assign exp_po_o      = q.epo;
    assign exp_bit_o     = q.rns[q.idx];
    assign cap_o         = (q.st == ST_CAPT);
    assign cmp_o         = chain_shift_o && q.live;
    assign last_o        = (q.idx == '0);
    assign halt_o        = (q.st == ST_HALT);

    AST_NO_READY_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        vec_ready_o |-> !(chain_ce_o && chain_shift_o)); // R5
    AST_CAPT_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_ce_o && !chain_shift_o) |-> $past(chain_ce_o && chain_shift_o)); // R4
    AST_PI_HELD_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SHIFT && q.idx != TOP_IDX) |-> $stable(chain_pi_o)); // R4

endmodule

// File: rtl/scanseq_check.sv
module scanseq_check #(
    parameter int NUM_PO    = 3,
    parameter int VEC_COUNT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [NUM_PO-1:0] po_i,
    input  logic [NUM_PO-1:0] exp_po_i,
    input  logic              cmp_i,
    input  logic              so_i,
    input  logic              exp_bit_i,
    input  logic              last_i,
    output logic              fail_o,
    output logic [$clog2(VEC_COUNT+1)-1:0] fail_cnt_o
);

    localparam int CW = $clog2(VEC_COUNT + 1);

    typedef struct packed {
        logic          bad;
        logic          sticky;
        logic [CW-1:0] cnt;
    } chk_t;

    chk_t q, d;
    logic po_mis, bit_mis;

    always_comb begin
        d       = q;
        po_mis  = cap_i && (po_i != exp_po_i);
        bit_mis = cmp_i && (so_i != exp_bit_i);
        if (cap_i) begin
            d.bad = po_mis;
        end else if (cmp_i) begin
            d.bad = q.bad | bit_mis;
            if (last_i && (q.bad || bit_mis)) d.cnt = q.cnt + 1'b1;
        end
        if (po_mis || bit_mis) d.sticky = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fail_o     = q.sticky;
    assign fail_cnt_o = q.cnt;

    AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> fail_o); // R9
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_cnt_o != $past(fail_cnt_o)) |-> (fail_cnt_o == $past(fail_cnt_o) + 1'b1)); // R8
    AST_COUNT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_cnt_o != '0) |-> fail_o); // R9

endmodule

// File: rtl/scanseq_clkcount.sv
module scanseq_clkcount #(
    parameter int NUM_SFF   = 8,
    parameter int VEC_COUNT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_i,
    output logic done_o
);

    localparam int TOTAL = (VEC_COUNT + 1) * NUM_SFF + VEC_COUNT;
    localparam int TW    = $clog2(TOTAL + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          done;
    } cc_t;

    cc_t q, d;

    always_comb begin
        d      = q;
        d.done = ce_i && (q.cnt == TW'(TOTAL - 1));
        if (ce_i) d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;

    AST_CLK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= TW'(TOTAL)); // R10
    AST_NO_CE_PAST_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == TW'(TOTAL)) |-> !ce_i); // R10

endmodule

// File: rtl/scanseq_top.sv
module scanseq_top #(
    parameter int NUM_PI    = 4,
    parameter int NUM_PO    = 3,
    parameter int NUM_SFF   = 8,
    parameter int VEC_COUNT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vec_valid,
    output logic               vec_ready,
    input  logic [NUM_PI-1:0]  vec_pi,
    input  logic [NUM_SFF-1:0] vec_ps,
    input  logic [NUM_PO-1:0]  vec_exp_po,
    input  logic [NUM_SFF-1:0] vec_exp_ns,
    output logic               scan_ce,
    output logic               scan_mode,
    output logic               scan_in,
    output logic [NUM_PI-1:0]  core_pi,
    input  logic               scan_out,
    input  logic [NUM_PO-1:0]  core_po,
    output logic               fail_flag,
    output logic [$clog2(VEC_COUNT+1)-1:0] fail_count,
    output logic               done
);

    logic [NUM_PO-1:0] exp_po;
    logic exp_bit, cap, cmp, last, halt;

    scanseq_ctrl #(
        .NUM_PI(NUM_PI), .NUM_PO(NUM_PO), .NUM_SFF(NUM_SFF), .VEC_COUNT(VEC_COUNT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .vec_valid_i(vec_valid), .vec_ready_o(vec_ready),
        .vec_pi_i(vec_pi), .vec_ps_i(vec_ps),
        .vec_exp_po_i(vec_exp_po), .vec_exp_ns_i(vec_exp_ns),
        .chain_ce_o(scan_ce), .chain_shift_o(scan_mode), .chain_si_o(scan_in),
        .chain_pi_o(core_pi), .exp_po_o(exp_po), .exp_bit_o(exp_bit),
        .cap_o(cap), .cmp_o(cmp), .last_o(last), .halt_o(halt)
    );

    scanseq_check #(
        .NUM_PO(NUM_PO), .VEC_COUNT(VEC_COUNT)
    ) u_check (
        .clk(clk), .rst_n(rst_n),
        .cap_i(cap), .po_i(core_po), .exp_po_i(exp_po),
        .cmp_i(cmp), .so_i(scan_out), .exp_bit_i(exp_bit), .last_i(last),
        .fail_o(fail_flag), .fail_cnt_o(fail_count)
    );

    scanseq_clkcount #(
        .NUM_SFF(NUM_SFF), .VEC_COUNT(VEC_COUNT)
    ) u_clkcount (
        .clk(clk), .rst_n(rst_n), .ce_i(scan_ce), .done_o(done)
    );

    AST_DONE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (halt && !scan_ce && !vec_ready)); // R10
    AST_HALT_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !vec_ready); // R7

endmodule

// File: tb/scanseq_top_tb.sv
`timescale 1ns/1ps
module scanseq_top_tb;

    localparam int P_PI  = 3;
    localparam int P_PO  = 2;
    localparam int P_SFF = 5;
    localparam int P_VEC = 5;
    localparam int P_TOT = (P_VEC + 1) * P_SFF + P_VEC;
    localparam int CW    = $clog2(P_VEC + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vec_valid = 1'b0;
    logic vec_ready;
    logic [P_PI-1:0]  vec_pi = '0;
    logic [P_SFF-1:0] vec_ps = '0;
    logic [P_PO-1:0]  vec_exp_po = '0;
    logic [P_SFF-1:0] vec_exp_ns = '0;
    logic scan_ce, scan_mode, scan_in;
    logic [P_PI-1:0] core_pi;
    logic scan_out;
    logic [P_PO-1:0] core_po;
    logic fail_flag;
    logic [CW-1:0] fail_count;
    logic done;

    always #2 clk = ~clk;

    scanseq_top #(
        .NUM_PI(P_PI), .NUM_PO(P_PO), .NUM_SFF(P_SFF), .VEC_COUNT(P_VEC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .vec_valid(vec_valid), .vec_ready(vec_ready),
        .vec_pi(vec_pi), .vec_ps(vec_ps),
        .vec_exp_po(vec_exp_po), .vec_exp_ns(vec_exp_ns),
        .scan_ce(scan_ce), .scan_mode(scan_mode), .scan_in(scan_in),
        .core_pi(core_pi), .scan_out(scan_out), .core_po(core_po),
        .fail_flag(fail_flag), .fail_count(fail_count), .done(done)
    );

    // circuit under test: 5-stage chain, stage 4 feeds scan_out
    function automatic logic [4:0] cut_ns(input logic [2:0] pi, input logic [4:0] s);
        return {s[3:0], s[4] ^ pi[0]} ^ {pi, 2'b01};
    endfunction
    function automatic logic [1:0] cut_po(input logic [2:0] pi, input logic [4:0] s);
        return {s[0] ^ pi[2], (s[4] & pi[1]) | s[2]};
    endfunction

    logic [4:0] cut_s;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cut_s <= '0;
        else if (scan_ce) cut_s <= scan_mode ? {cut_s[3:0], scan_in} : cut_ns(core_pi, cut_s);
    end
    assign scan_out = cut_s[4];
    assign core_po  = cut_po(core_pi, cut_s);

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard queues
    logic q_si[$];
    logic [P_PI-1:0] q_pi[$];

    int  ce_cnt = 0;
    int  shift_run = 0;
    int  n_capt = 0;
    bit  prev_done = 1'b0;
    bit  done_seen = 1'b0;

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
            prev_done = done;
            if (scan_ce) begin
                ce_cnt++;
                if (scan_mode) begin
                    shift_run++;
                    chk(vec_ready == 1'b0, "R5 ready low in shift", int'(vec_ready), 0);
                    if (q_si.size() > 0) begin
                        logic e;
                        e = q_si.pop_front();
                        chk(scan_in == e, "R3 scan_in bit", int'(scan_in), int'(e));
                        chk(core_pi == q_pi[0], "R4 pi held in shift", int'(core_pi), int'(q_pi[0]));
                    end
                end else begin
                    chk(shift_run == P_SFF, "R3 shift length", shift_run, P_SFF);
                    shift_run = 0;
                    if (q_pi.size() > 0) begin
                        logic [P_PI-1:0] ep;
                        ep = q_pi.pop_front();
                        chk(core_pi == ep, "R4 pi at capture", int'(core_pi), int'(ep));
                    end else begin
                        chk(1'b0, "R4 unexpected capture", n_capt, P_VEC);
                    end
                    if (n_capt == P_VEC - 1)
                        chk(vec_ready == 1'b0, "R7 ready low at last capture", int'(vec_ready), 0);
                    else
                        chk(vec_ready == 1'b1, "R5 ready high at capture", int'(vec_ready), 1);
                    n_capt++;
                end
            end
            if (done) begin
                done_seen = 1'b1;
                chk(ce_cnt == P_TOT, "R10 enabled clock total", ce_cnt, P_TOT);
                chk(shift_run == P_SFF, "R7 unload length", shift_run, P_SFF);
                chk(scan_ce == 1'b0, "R10 halted at done", int'(scan_ce), 0);
            end
        end
    end

    // driver: call at a negedge; returns at the negedge after acceptance
    task automatic send(input int k, output int waits);
        logic [P_PI-1:0]  pi;
        logic [P_SFF-1:0] ps, ens;
        logic [P_PO-1:0]  epo;
        logic r;
        pi  = P_PI'(k * 5 + 5);
        ps  = P_SFF'(k * 11 + 21);
        epo = cut_po(pi, ps) ^ ((k == 1) ? 2'b01 : 2'b00);
        ens = cut_ns(pi, ps) ^ ((k == 3) ? 5'b00100 : (k == 4) ? 5'b00001 : 5'b00000);
        for (int b = P_SFF - 1; b >= 0; b--) q_si.push_back(ps[b]);
        q_pi.push_back(pi);
        vec_pi = pi; vec_ps = ps; vec_exp_po = epo; vec_exp_ns = ens;
        vec_valid = 1'b1;
        waits = 0;
        while (1) begin
            r = vec_ready;
            @(negedge clk);
            if (r) break;
            waits++;
        end
        vec_valid = 1'b0;
    endtask

    initial begin
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scan_ce == 1'b0, "R1 ce after reset", int'(scan_ce), 0);
        chk(vec_ready == 1'b1, "R1 ready after reset", int'(vec_ready), 1);
        chk(done == 1'b0, "R1 done after reset", int'(done), 0);
        chk(fail_flag == 1'b0, "R1 flag after reset", int'(fail_flag), 0);
        chk(fail_count == '0, "R1 count after reset", int'(fail_count), 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(scan_ce == 1'b0 && vec_ready == 1'b1, "R2 idle before first vector", int'(scan_ce), 0);
        end
        send(0, w);
        send(1, w);
        chk(w == P_SFF, "R5 back-to-back accept at capture", w, P_SFF);
        while (!(scan_ce && !scan_mode)) @(negedge clk);
        chk(fail_flag == 1'b0, "R9 R6 clean first vector", int'(fail_flag), 0);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(scan_ce == 1'b0, "R2 stall no ce", int'(scan_ce), 0);
            chk(vec_ready == 1'b1, "R2 stall ready", int'(vec_ready), 1);
            chk(fail_flag == 1'b1, "R9 R6 po mismatch flagged", int'(fail_flag), 1);
            chk(fail_count == '0, "R8 count not yet updated", int'(fail_count), 0);
        end
        send(2, w);
        send(3, w);
        send(4, w);
        for (int i = 0; i < 200 && !done_seen; i++) @(negedge clk);
        chk(done_seen, "R10 done seen", int'(done_seen), 1);
        chk(fail_count == CW'(3), "R8 failing vectors", int'(fail_count), 3);
        chk(fail_flag == 1'b1, "R9 flag kept", int'(fail_flag), 1);
        vec_valid = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(vec_ready == 1'b0, "R7 no vector after unload", int'(vec_ready), 0);
            chk(scan_ce == 1'b0, "R10 ce low after done", int'(scan_ce), 0);
        end
        vec_valid = 1'b0;
        chk(q_si.size() == 0, "R3 all bits shifted", q_si.size(), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R10 actual=%0d expected=%0d", ce_cnt, P_TOT);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule